// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block runs a sampling converter that has a serial result port, from the host side. When a start request arrives, it pulls chip select and read/convert low for a fixed number of system clock cycles to begin a conversion. It then watches the converter's busy flag. Once busy has gone low and then high again, the fresh result is ready. The controller then holds chip select low and read/convert high and runs a burst of data clock pulses. The serial word is captured most significant bit first into a parallel register. A one-cycle valid strobe goes out together with the 16-bit word.

A mode input lets the controller fetch the previous result while the new conversion is still running. This is allowed only when the whole burst ends inside a safe window measured from conversion start. The window is 12 microseconds, converted to cycles from the system clock frequency parameter. When the burst at the configured data clock rate would run past that window, the early read is dropped for that build. The controller then waits for busy to rise and reads the new result instead, so no data clock edge ever falls between the window's end and the rise of busy.

The controller has four states. ST_IDLE goes to ST_CONVERT on a start request. ST_CONVERT goes to ST_READ (early read) or to ST_WAIT_BUSY at the end of the conversion pulse. ST_WAIT_BUSY goes to ST_READ (late read), or back to ST_IDLE after an early read, once busy has fallen and risen again. ST_READ goes to ST_WAIT_BUSY (early read) or to ST_IDLE (late read) when the burst is finished.

Top module: `adc_readout_ctrl`

## Requirements
- R1: During and right after reset, cs_n and rc_n are high, dclk is low and result_valid is low.
- R2: A start request accepted in ST_IDLE drives rc_n low, together with cs_n low, for exactly CONV_CYC consecutive system cycles. It starts exactly one conversion.
- R3: A start request that arrives while the controller is not in ST_IDLE is ignored, so one request held high over several cycles starts only one conversion.
- R4: With early reads off, no data clock edge occurs while busy is low. The read starts only after busy has gone low and then high, and it returns the word of the conversion just started.
- R5: While dclk is high, cs_n is low and rc_n is high. A read burst has DATA_W+1 rising dclk edges: one lead-in edge, then one edge per bit.
- R6: The bit presented after falling dclk edge k (k = 1 first) is sampled at rising edge k+1. The first presented bit lands in result_data[DATA_W-1], so the word is assembled MSB first.
- R7: result_valid is high for exactly one system cycle per read burst, and result_data holds the captured word during that cycle.
- R8: With early reads on and the burst fitting the window, the read starts as soon as the conversion pulse ends, during busy low. It returns the previous conversion's word. The controller then waits for busy high and goes back to ST_IDLE without a second read.
- R9: With early reads on but a burst longer than the window allows, no data clock edge occurs while busy is low. The read waits for busy high and returns the new word.
- R10: No dclk edge occurs while busy is low once WINDOW_US microseconds of system cycles have passed since rc_n fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a conversion and readout |
| early_read_en | input | 1 | 1: fetch the previous result during the conversion when it fits |
| busy_in | input | 1 | Converter busy flag, low while converting |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| rc_n | output | 1 | Read/convert: low starts a conversion, high selects read |
| dclk | output | 1 | Data clock to the converter |
| result_valid | output | 1 | One-cycle strobe when a word has been captured |
| result_data | output | DATA_W | Captured result word |

## Verification
The bench pairs two controllers with a converter model. One has a fast data clock so early reads fit, and the other has a slow clock so they must be postponed. An early read that picked up the new word, or a postponed read that ran during busy low, shows up at once as a wrong word or as data clock edges inside the conversion. Start requests held high for up to four cycles catch a controller that restarts a conversion outside idle. Random bits driven before the first falling edge catch an off-by-one in sampling, which would shift the word by one place. Early transactions right after reset and back to back check that the controller does not read twice per conversion and does return to idle.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CONVERT   = 2'd1,
        ST_WAIT_BUSY = 2'd2,
        ST_READ      = 2'd3
    } rd_state_t;

endpackage

// File: rtl/adc_dclk_gen.sv
`timescale 1ns/1ps
module adc_dclk_gen #(
    parameter int unsigned HALF_CYC   = 2,
    parameter int unsigned NUM_PULSES = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dclk,
    output logic sample_stb,
    output logic frame_done
);
    localparam int unsigned NUM_HALVES = 2 * NUM_PULSES;
    localparam int unsigned IW = $clog2(NUM_HALVES);
    localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [HW-1:0] half_cnt;
    logic [IW-1:0] idx;
    logic          half_end;

    assign half_end   = (half_cnt == HW'(HALF_CYC - 1));
    // even half-period ending, not the first: the next edge is a sampling rise
    assign sample_stb = run && half_end && !idx[0] && (idx != '0);
    assign frame_done = run && half_end && (idx == IW'(NUM_HALVES - 1));
    assign dclk       = run && idx[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            idx      <= '0;
        end else if (!run || frame_done) begin
            half_cnt <= '0;
            idx      <= '0;
        end else if (half_end) begin
            half_cnt <= '0;
            idx      <= idx + 1'b1;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_shift_capture.sv
`timescale 1ns/1ps
module adc_shift_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_stb,
    input  logic              sdata_in,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data
);
    localparam int unsigned CW = $clog2(DATA_W + 1);

    logic [DATA_W-2:0] shift_q;
    logic [CW-1:0]     bit_cnt;
    logic              last_bit;

    assign last_bit = (bit_cnt == CW'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q      <= '0;
            bit_cnt      <= '0;
            result_valid <= 1'b0;
            result_data  <= '0;
        end else begin
            result_valid <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (sample_stb) begin
                shift_q <= {shift_q[DATA_W-3:0], sdata_in};
                if (last_bit) begin
                    bit_cnt      <= '0;
                    result_valid <= 1'b1;
                    result_data  <= {shift_q, sdata_in};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_readout_ctrl.sv
`timescale 1ns/1ps
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned WINDOW_US = 12,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CONV_CYC  = 3,
    parameter int unsigned HALF_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              early_read_en,
    input  logic              busy_in,
    input  logic              sdata_in,
    output logic              cs_n,
    output logic              rc_n,
    output logic              dclk,
    output logic              result_valid,
    output logic [DATA_W-1:0] result_data
);
    localparam int unsigned WIN_CYC    = (CLK_HZ / 1000) * WINDOW_US / 1000;
    localparam int unsigned NUM_PULSES = DATA_W + 1;
    localparam int unsigned READ_CYC   = 2 * NUM_PULSES * HALF_CYC;
    localparam bit          EARLY_FITS = (CONV_CYC + READ_CYC) < WIN_CYC;
    localparam int unsigned CW         = $clog2(CONV_CYC + 1);

    rd_state_t     state, state_nx;
    logic [CW-1:0] conv_cnt;
    logic          busy_fell;
    logic          early_rd;
    logic          run;
    logic          sample_stb;
    logic          frame_done;
    logic          conv_end;
    logic          busy_back;

    assign conv_end  = (conv_cnt == CW'(CONV_CYC - 1));
    assign busy_back = busy_fell && busy_in;
    assign run       = (state == ST_READ);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_req) state_nx = ST_CONVERT;
            ST_CONVERT:   if (conv_end)
                              state_nx = (early_read_en && EARLY_FITS) ? ST_READ : ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (busy_back)
                              state_nx = early_rd ? ST_IDLE : ST_READ;
            ST_READ:      if (frame_done)
                              state_nx = early_rd ? ST_WAIT_BUSY : ST_IDLE;
        endcase
    end

    // state register and per-conversion bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            conv_cnt  <= '0;
            busy_fell <= 1'b0;
            early_rd  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_req) begin
                conv_cnt  <= '0;
                busy_fell <= 1'b0;
                early_rd  <= 1'b0;
            end else begin
                if (state == ST_CONVERT) conv_cnt <= conv_cnt + 1'b1;
                if (!busy_in) busy_fell <= 1'b1;
                if (state == ST_CONVERT && state_nx == ST_READ) early_rd <= 1'b1;
            end
        end
    end

    // pin outputs
    always_comb begin
        cs_n = 1'b1;
        rc_n = 1'b1;
        unique case (state)
            ST_IDLE:      ;
            ST_CONVERT:   begin cs_n = 1'b0; rc_n = 1'b0; end
            ST_WAIT_BUSY: ;
            ST_READ:      cs_n = 1'b0;
        endcase
    end

    adc_dclk_gen #(
        .HALF_CYC   (HALF_CYC),
        .NUM_PULSES (NUM_PULSES)
    ) u_dclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dclk       (dclk),
        .sample_stb (sample_stb),
        .frame_done (frame_done)
    );

    adc_shift_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (!run),
        .sample_stb   (sample_stb),
        .sdata_in     (sdata_in),
        .result_valid (result_valid),
        .result_data  (result_data)
    );
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
`timescale 1ns/1ps
module adc_readout_ctrl_chk #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned WINDOW_US = 12,
    parameter int unsigned CONV_CYC  = 3
) (
    input logic clk,
    input logic rst_n,
    input logic busy_in,
    input logic cs_n,
    input logic rc_n,
    input logic dclk,
    input logic result_valid
);
    localparam int unsigned WIN_CYC = (CLK_HZ / 1000) * WINDOW_US / 1000;

    logic [15:0] lo_cnt;
    logic [31:0] elapsed;
    logic        rc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            elapsed <= '0;
            rc_q    <= 1'b1;
        end else begin
            rc_q   <= rc_n;
            lo_cnt <= rc_n ? 16'd0 : lo_cnt + 16'd1;
            if (rc_q && !rc_n)            elapsed <= 32'd1;
            else if (elapsed != '0 && elapsed != '1) elapsed <= elapsed + 32'd1;
        end
    end

    // R2
    conv_low_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_n |-> !cs_n);
    // R2
    conv_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= 16'(CONV_CYC));
    // R2
    conv_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_n) |-> lo_cnt == 16'(CONV_CYC));
    // R5
    read_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> (!cs_n && rc_n));
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R10
    window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_in && elapsed > WIN_CYC) |-> $stable(dclk));
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .CLK_HZ    (CLK_HZ),
    .WINDOW_US (WINDOW_US),
    .CONV_CYC  (CONV_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_in      (busy_in),
    .cs_n         (cs_n),
    .rc_n         (rc_n),
    .dclk         (dclk),
    .result_valid (result_valid)
);

// File: tb/adc_readout_ctrl_bench.sv
`timescale 1ns/1ps
module adc_conv_model #(
    parameter int DATA_W = 16,
    parameter int CONV_T = 1600,
    parameter int WIN    = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rc_n,
    input  logic              dclk,
    output logic              busy,
    output logic              sdata,
    output int                conv_cnt,
    output logic [DATA_W-1:0] pending,
    output logic [DATA_W-1:0] held,
    output int                viol,
    output int                rises,
    output int                busy_edges
);
    logic              prev_rc, prev_dclk, in_read;
    logic [DATA_W-1:0] rd_word;
    int                timer, elapsed, bitpos;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1; sdata <= 1'b0; conv_cnt <= 0; pending <= '0; held <= '0;
            viol <= 0; rises <= 0; busy_edges <= 0; prev_rc <= 1'b1; prev_dclk <= 1'b0;
            in_read <= 1'b0; rd_word <= '0; timer <= 0; elapsed <= 0; bitpos <= 0;
        end else begin
            prev_rc   <= rc_n;
            prev_dclk <= dclk;
            in_read   <= !cs_n && rc_n;
            if (prev_rc && !rc_n && !cs_n && busy) begin
                busy     <= 1'b0;
                timer    <= CONV_T;
                pending  <= DATA_W'($urandom);
                conv_cnt <= conv_cnt + 1;
                elapsed  <= 0;
            end else begin
                if (elapsed < 32'h3fff_ffff) elapsed <= elapsed + 1;
                if (!busy) begin
                    if (timer <= 1) begin busy <= 1'b1; held <= pending; end
                    else timer <= timer - 1;
                end
            end
            if (!cs_n && rc_n && !in_read) begin
                rd_word <= held;
                bitpos  <= 0;
                rises   <= 0;
                sdata   <= 1'($urandom);
            end else if (!cs_n && rc_n) begin
                if (prev_dclk && !dclk) begin
                    sdata  <= (bitpos < DATA_W) ? rd_word[DATA_W-1-bitpos] : 1'($urandom);
                    bitpos <= bitpos + 1;
                end
                if (!prev_dclk && dclk) rises <= rises + 1;
            end
            if (dclk != prev_dclk && !busy) begin
                busy_edges <= busy_edges + 1;
                if (elapsed >= WIN - 1) viol <= viol + 1;
            end
        end
    end
endmodule

module adc_readout_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100_000_000;
    localparam int WIN        = 1200;
    localparam int CONV_T     = 1600;
    localparam int CONV_CYC   = 3;
    localparam int DATA_W     = 16;
    localparam int PULSES     = DATA_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] start_req = '0;
    logic [1:0] early_en = '0;
    logic [1:0] busy, sdata, cs_n, rc_n, dclk, rvalid;
    logic [DATA_W-1:0] rdata [2];
    logic [DATA_W-1:0] pending [2];
    logic [DATA_W-1:0] held [2];
    int conv_cnt [2];
    int viol [2];
    int rises [2];
    int busy_edges [2];
    int vcnt [2];
    int lowrun [2];
    int lastlow [2];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_readout_ctrl #(.CLK_HZ(CLK_HZ), .WINDOW_US(12), .DATA_W(DATA_W),
                       .CONV_CYC(CONV_CYC), .HALF_CYC(2)) u_adc_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req[0]), .early_read_en(early_en[0]),
        .busy_in(busy[0]), .sdata_in(sdata[0]), .cs_n(cs_n[0]), .rc_n(rc_n[0]),
        .dclk(dclk[0]), .result_valid(rvalid[0]), .result_data(rdata[0]));

    adc_readout_ctrl #(.CLK_HZ(CLK_HZ), .WINDOW_US(12), .DATA_W(DATA_W),
                       .CONV_CYC(CONV_CYC), .HALF_CYC(40)) u_adc_readout_ctrl_slow (
        .clk(clk), .rst_n(rst_n), .start_req(start_req[1]), .early_read_en(early_en[1]),
        .busy_in(busy[1]), .sdata_in(sdata[1]), .cs_n(cs_n[1]), .rc_n(rc_n[1]),
        .dclk(dclk[1]), .result_valid(rvalid[1]), .result_data(rdata[1]));

    for (genvar g = 0; g < 2; g++) begin : g_model
        adc_conv_model #(.DATA_W(DATA_W), .CONV_T(CONV_T), .WIN(WIN)) u_model (
            .clk(clk), .rst_n(rst_n), .cs_n(cs_n[g]), .rc_n(rc_n[g]), .dclk(dclk[g]),
            .busy(busy[g]), .sdata(sdata[g]), .conv_cnt(conv_cnt[g]),
            .pending(pending[g]), .held(held[g]), .viol(viol[g]),
            .rises(rises[g]), .busy_edges(busy_edges[g]));
    end

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) if (rst_n && rvalid[i]) vcnt[i] = vcnt[i] + 1;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin lowrun[i] = 0; lastlow[i] = 0; end
            else if (!rc_n[i]) lowrun[i] = lowrun[i] + 1;
            else if (lowrun[i] != 0) begin lastlow[i] = lowrun[i]; lowrun[i] = 0; end
        end
    end

    function automatic logic [DATA_W-1:0] exp_word(input bit early_fit,
                                                   input logic [DATA_W-1:0] fresh,
                                                   input logic [DATA_W-1:0] prior);
        return early_fit ? prior : fresh;
    endfunction

    task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_txn(input int sel, input bit early, input int hold);
        int c0, v0, e0, tmo;
        bit fit;
        logic [DATA_W-1:0] exp;
        fit = early && (sel == 0);
        @(negedge clk);
        early_en[sel] = early;
        c0 = conv_cnt[sel];
        v0 = vcnt[sel];
        e0 = busy_edges[sel];
        start_req[sel] = 1'b1;
        repeat (hold) @(negedge clk);
        start_req[sel] = 1'b0;
        tmo = 0;
        while (conv_cnt[sel] == c0 && tmo < 50) begin @(posedge clk); #1; tmo++; end
        chk("R2 conversion started", conv_cnt[sel] == c0 + 1, conv_cnt[sel], c0 + 1);
        exp = exp_word(fit, pending[sel], held[sel]);
        tmo = 0;
        while (!rvalid[sel] && tmo < 5000) begin @(posedge clk); #1; tmo++; end
        chk(fit ? "R8 early word" : (early ? "R9 postponed word" : "R6 MSB-first word"),
            rvalid[sel] && rdata[sel] == exp, rdata[sel], exp);
        @(posedge clk); #1;
        chk("R7 valid one cycle", !rvalid[sel], rvalid[sel], 0);
        chk("R5 rising edges per burst", rises[sel] == PULSES, rises[sel], PULSES);
        tmo = 0;
        while (!(cs_n[sel] && busy[sel] && rc_n[sel]) && tmo < 5000) begin @(posedge clk); #1; tmo++; end
        repeat (20) @(posedge clk);
        #1;
        chk("R3 single conversion", conv_cnt[sel] == c0 + 1, conv_cnt[sel], c0 + 1);
        chk(fit ? "R8 single read" : "R4 single read", vcnt[sel] == v0 + 1, vcnt[sel], v0 + 1);
        chk("R2 pulse length", lastlow[sel] == CONV_CYC, lastlow[sel], CONV_CYC);
        if (fit)
            chk("R8 read inside conversion", busy_edges[sel] > e0, busy_edges[sel] - e0, 1);
        else
            chk(early ? "R9 no clock while busy" : "R4 no clock while busy",
                busy_edges[sel] == e0, busy_edges[sel] - e0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a));
        vcnt[0] = 0; vcnt[1] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 cs_n in reset", cs_n == 2'b11, cs_n, 2'b11);
        chk("R1 rc_n in reset", rc_n == 2'b11, rc_n, 2'b11);
        chk("R1 dclk in reset", dclk == 2'b00, dclk, 0);
        chk("R1 valid in reset", rvalid == 2'b00, rvalid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 idle after reset", cs_n == 2'b11 && rc_n == 2'b11 && dclk == 2'b00,
            {cs_n, rc_n, dclk}, 6'b111100);
        // directed: early read first (previous word is the reset value), long hold (R3)
        run_txn(0, 1'b1, 4);
        run_txn(0, 1'b1, 1);
        run_txn(0, 1'b0, 4);
        run_txn(0, 1'b0, 1);
        run_txn(1, 1'b1, 4);
        run_txn(1, 1'b0, 2);
        for (int t = 0; t < 18; t++) run_txn(0, 1'($urandom), 1 + ($urandom % 4));
        for (int t = 0; t < 5; t++) run_txn(1, 1'($urandom), 1 + ($urandom % 4));
        // R10 forbidden window never clocked
        chk("R10 window fast", viol[0] == 0, viol[0], 0);
        chk("R10 window slow", viol[1] == 0, viol[1], 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule